// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent translations from 32-bit linear addresses to physical addresses for 4 KiB pages. The upper 20 address bits form the virtual page number. The low 12 bits are the page offset, which is passed through unchanged. Each stored entry holds a virtual page tag, a physical page number, a valid flag and a global flag. The entries are arranged as `SETS` sets of `WAYS` ways. The default is 4 sets by 8 ways, which gives 32 entries. With `WAYS=1` the buffer becomes direct-mapped.

A requester presents an address on the lookup port and sees hit or miss, together with the physical address, in the same cycle. After a miss, the page walker that sits outside this block writes the translation it found through the fill port.

Two maintenance commands keep the buffer consistent with the page tables:
- A bulk flush, issued when the page-table base changes, drops every entry that is not marked global.
- A targeted invalidate drops the single entry that holds one page.

Top module: `xlat_tlb`

## Requirements
- R1: After a synchronous reset every entry is invalid, so every lookup misses.
- R2: Lookup is combinational. On a hit, `lk_paddr` is the stored physical page number in bits 31:12 followed by `lk_laddr[11:0]`. On a miss, `lk_hit` is 0 and `lk_paddr` is 0.
- R3: The set is chosen by the low log2(SETS) bits of the page number, which is the page number modulo SETS. The remaining bits are the tag. Pages that differ only above the index share a set and can be resident at the same time.
- R4: A fill takes effect at the next rising edge, after which a lookup of that page hits with the supplied physical page number. If no fill, flush or invalidate is asserted, the translation seen for an unchanged lookup address does not change.
- R5: A fill into a set that holds no copy of the page goes to the lowest-numbered invalid way. If every way is valid, it goes to the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one, modulo WAYS, on every accepted fill into the set.
- R6: A fill for a page that is already resident overwrites that way, so no duplicate is created.
- R7: A flush clears every entry whose global flag is 0 and leaves global entries valid. A fill in the same cycle is written after the flush and survives it.
- R8: An invalidate clears only the entry holding its page, whether or not that entry is global. An invalidate for a page that is not resident changes nothing.
- R9: When a fill and an invalidate name the same page in the same cycle, the invalidate wins. The fill is dropped and the round-robin pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_laddr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | PPN_W+12 | Physical address on a hit, 0 on a miss |
| fill_en | input | 1 | Write a translation |
| fill_laddr | input | 32 | Linear address whose page is being filled |
| fill_ppn | input | PPN_W | Physical page number for the fill |
| fill_global | input | 1 | Mark the filled entry global |
| flush_en | input | 1 | Page-table base changed: drop all non-global entries |
| inv_en | input | 1 | Invalidate one page |
| inv_laddr | input | 32 | Linear address whose page is invalidated |

## Verification
The bound assertions check four properties on every cycle:
- the first lookup after reset misses;
- a filled page is visible with its new physical page on the next cycle;
- an invalidated page misses on the next cycle;
- an idle cycle leaves the translation of an unchanged address untouched.

Only the bench scenarios can show the following:
- the replacement order, both first-invalid and round-robin;
- the survival of global entries across a flush;
- that a fill for a resident page leaves no hidden duplicate;
- the dropped fill when a fill and an invalidate collide.

The bench checks these against a behavioural model that is compared on every clock.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 18
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            vld,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[w] && (tags[w] == tag);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [WAYS-1:0]  hit_vec,
  input  logic [WAY_W-1:0] rr,
  output logic [WAY_W-1:0] way
);
  logic [WAY_W-1:0] hit_way, free_way;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    // descending scan: the lowest matching index is assigned last
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!vld[w])    free_way = WAY_W'(w);
    end
    if (|hit_vec)       way = hit_way;
    else if (!(&vld))   way = free_way;
    else                way = rr;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xtlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 8,
  parameter int PPN_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [VA_W-1:0]       lk_laddr,
  output logic                  lk_hit,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic                  fill_en,
  input  logic [VA_W-1:0]       fill_laddr,
  input  logic [PPN_W-1:0]      fill_ppn,
  input  logic                  fill_global,
  input  logic                  flush_en,
  input  logic                  inv_en,
  input  logic [VA_W-1:0]       inv_laddr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = VPN_W - IDX_W;

  // entry storage; payload has no reset, flags do
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][PPN_W-1:0] ppn_q [SETS];
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            glb_q [SETS];
  logic [WAY_W-1:0]           rr_q  [SETS];

  // address split for the three access paths
  logic [VPN_W-1:0] lk_vpn, fl_vpn, iv_vpn;
  logic [IDX_W-1:0] lk_idx, fl_idx, iv_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;

  assign lk_vpn = lk_laddr[VA_W-1:OFF_W];
  assign fl_vpn = fill_laddr[VA_W-1:OFF_W];
  assign iv_vpn = inv_laddr[VA_W-1:OFF_W];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign fl_idx = fl_vpn[IDX_W-1:0];
  assign iv_idx = iv_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_tag = fl_vpn[VPN_W-1:IDX_W];
  assign iv_tag = iv_vpn[VPN_W-1:IDX_W];

  logic unused_offsets;
  assign unused_offsets = ^{fill_laddr[OFF_W-1:0], inv_laddr[OFF_W-1:0]};

  logic [WAYS-1:0] lk_vec, fl_vec, iv_vec;

  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .tags(tag_q[lk_idx]), .vld(vld_q[lk_idx]), .tag(lk_tag), .hit_vec(lk_vec));
  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .tags(tag_q[fl_idx]), .vld(vld_q[fl_idx]), .tag(fl_tag), .hit_vec(fl_vec));
  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_iv_match (
    .tags(tag_q[iv_idx]), .vld(vld_q[iv_idx]), .tag(iv_tag), .hit_vec(iv_vec));

  // lookup result
  logic [PPN_W-1:0] lk_ppn;
  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_vec[w]) lk_ppn = lk_ppn | ppn_q[lk_idx][w];
  end
  assign lk_hit   = |lk_vec;
  assign lk_paddr = lk_hit ? {lk_ppn, lk_laddr[OFF_W-1:0]} : '0;

  // fill way selection
  logic [WAY_W-1:0] fl_way;
  logic             fill_ok;

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .vld(vld_q[fl_idx]), .hit_vec(fl_vec), .rr(rr_q[fl_idx]), .way(fl_way));

  assign fill_ok = fill_en && !(inv_en && (iv_vpn == fl_vpn));

  // per-entry clear and set masks
  logic [WAYS-1:0] clr_m [SETS];
  logic [WAYS-1:0] set_m [SETS];
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        clr_m[s][w] = (flush_en && !glb_q[s][w]) ||
                      (inv_en && (iv_idx == IDX_W'(s)) && iv_vec[w]);
        set_m[s][w] = fill_ok && (fl_idx == IDX_W'(s)) && (fl_way == WAY_W'(w));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        glb_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= (vld_q[s] & ~clr_m[s]) | set_m[s];
        glb_q[s] <= (glb_q[s] & ~set_m[s]) | (set_m[s] & {WAYS{fill_global}});
        if (fill_ok && (fl_idx == IDX_W'(s)))
          rr_q[s] <= (rr_q[s] == WAY_W'(WAYS - 1)) ? '0 : rr_q[s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[fl_idx][fl_way] <= fl_tag;
      ppn_q[fl_idx][fl_way] <= fill_ppn;
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
  import xtlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 8,
  parameter int PPN_W = 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic [VA_W-1:0]        lk_laddr,
  input logic                   lk_hit,
  input logic [PPN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_en,
  input logic [VA_W-1:0]        fill_laddr,
  input logic [PPN_W-1:0]       fill_ppn,
  input logic                   fill_global,
  input logic                   flush_en,
  input logic                   inv_en,
  input logic [VA_W-1:0]        inv_laddr
);
  logic unused_chk;
  assign unused_chk = fill_global;

  // R1: first lookup after reset misses
  p_reset_miss_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R4: filled page visible next cycle unless cancelled by an invalidate
  p_fill_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(inv_en && inv_laddr[VA_W-1:OFF_W] == fill_laddr[VA_W-1:OFF_W]))
    |=> (lk_laddr[VA_W-1:OFF_W] != $past(fill_laddr[VA_W-1:OFF_W])) ||
        (lk_hit && lk_paddr[PPN_W+OFF_W-1:OFF_W] == $past(fill_ppn)));

  // R8: invalidated page misses next cycle
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> (lk_laddr[VA_W-1:OFF_W] != $past(inv_laddr[VA_W-1:OFF_W])) || !lk_hit);

  // R4: no command, unchanged address -> unchanged translation
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!fill_en && !inv_en && !flush_en)
    |=> !$stable(lk_laddr) || ($stable(lk_hit) && $stable(lk_paddr)));
endmodule

bind xlat_tlb xlat_tlb_chk #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_chk (.*);

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
  localparam int SETS = 4;
  localparam int WAYS = 8;
  localparam int PPN_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] lk_laddr = '0, fill_laddr = '0, inv_laddr = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic fill_en = 0, fill_global = 0, flush_en = 0, inv_en = 0;
  logic lk_hit;
  logic [31:0] lk_paddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_tlb #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_dut (.*);

  // behavioural reference
  int m_vpn [SETS][WAYS];
  int m_ppn [SETS][WAYS];
  bit m_v   [SETS][WAYS];
  bit m_g   [SETS][WAYS];
  int m_rr  [SETS];

  always @(posedge clk) begin
    int fv, fs, fw, iv, is;
    bit conflict;
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        m_rr[s] = 0;
        for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_g[s][w] = 0; end
      end
    end else begin
      fv = int'(fill_laddr[31:12]);
      fs = fv % SETS;
      iv = int'(inv_laddr[31:12]);
      is = iv % SETS;
      conflict = inv_en && (iv == fv);
      fw = -1;
      for (int w = 0; w < WAYS; w++)
        if (fw < 0 && m_v[fs][w] && m_vpn[fs][w] == fv) fw = w;
      for (int w = 0; w < WAYS; w++)
        if (fw < 0 && !m_v[fs][w]) fw = w;
      if (fw < 0) fw = m_rr[fs];
      if (flush_en)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!m_g[s][w]) m_v[s][w] = 0;
      if (inv_en)
        for (int w = 0; w < WAYS; w++)
          if (m_v[is][w] && m_vpn[is][w] == iv) m_v[is][w] = 0;
      if (fill_en && !conflict) begin
        m_v[fs][fw] = 1; m_g[fs][fw] = fill_global;
        m_vpn[fs][fw] = fv; m_ppn[fs][fw] = int'(fill_ppn);
        m_rr[fs] = (m_rr[fs] + 1) % WAYS;
      end
    end
  end

  task automatic check(string tag, bit gh, bit eh, logic [31:0] gp, logic [31:0] ep);
    n_chk++;
    if (gh !== eh || gp !== ep) begin
      n_fail++;
      $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h", tag, gh, gp, eh, ep);
    end
  endtask

  // every-clock comparison against the model (R2)
  always @(negedge clk) begin
    int v, s;
    bit eh;
    logic [31:0] ep;
    #5;
    if (!rst && !done) begin
      v = int'(lk_laddr[31:12]); s = v % SETS;
      eh = 0; ep = '0;
      for (int w = 0; w < WAYS; w++)
        if (m_v[s][w] && m_vpn[s][w] == v) begin
          eh = 1; ep = {m_ppn[s][w][19:0], lk_laddr[11:0]};
        end
      check("R2 model", lk_hit, eh, lk_paddr, ep);
    end
  end

  task automatic look(logic [31:0] a, bit eh, logic [31:0] ep, string tag);
    lk_laddr = a;
    #1;
    check(tag, lk_hit, eh, lk_paddr, ep);
  endtask

  task automatic cmd(bit fe, int fv, int fp, bit fg, bit fl, bit ie, int iv);
    @(negedge clk);
    fill_en = fe; fill_laddr = {fv[19:0], 12'h0}; fill_ppn = fp[19:0]; fill_global = fg;
    flush_en = fl; inv_en = ie; inv_laddr = {iv[19:0], 12'h0};
    @(negedge clk);
    fill_en = 0; flush_en = 0; inv_en = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    look(32'h0000_1234, 0, 32'h0, "R1 reset miss");
    look(32'hFFFF_F000, 0, 32'h0, "R1 reset miss high page");

    cmd(1, 'h12346, 'hABCDE, 0, 0, 0, 0);
    look(32'h1234_67A5, 1, 32'hABCD_E7A5, "R4 fill hit, R2 offset");
    look(32'h1234_77A5, 0, 32'h0, "R2 miss zero");

    for (int k = 0; k < 10; k++) cmd(1, 1 + 4 * k, 'h100 + k, 0, 0, 0, 0);
    look(32'h0000_1000, 0, 32'h0, "R5 rr evicts way0");
    look(32'h0000_5000, 0, 32'h0, "R5 rr evicts way1");
    look(32'h0000_9ABC, 1, 32'h0010_2ABC, "R5 survivor");
    look(32'h0002_5000, 1, 32'h0010_9000, "R3 same set resident");

    cmd(1, 9, 'h777, 0, 0, 0, 0);
    look(32'h0000_9001, 1, 32'h0077_7001, "R6 overwrite");
    cmd(0, 0, 0, 0, 0, 1, 9);
    look(32'h0000_9001, 0, 32'h0, "R6 no duplicate");
    look(32'h0000_D010, 1, 32'h0010_3010, "R8 neighbour kept");

    cmd(1, 'h42, 'h55, 1, 0, 0, 0);
    cmd(1, 'h50, 'h66, 0, 1, 0, 0);
    look(32'h1234_6000, 0, 32'h0, "R7 non-global flushed");
    look(32'h0000_D000, 0, 32'h0, "R7 non-global flushed set1");
    look(32'h0004_2123, 1, 32'h0005_5123, "R7 global kept");
    look(32'h0005_0FFF, 1, 32'h0006_6FFF, "R7 same-cycle fill kept");

    cmd(0, 0, 0, 0, 0, 1, 'h99999);
    look(32'h0004_2000, 1, 32'h0005_5000, "R8 absent invalidate");
    cmd(0, 0, 0, 0, 0, 1, 'h42);
    look(32'h0004_2000, 0, 32'h0, "R8 global invalidated");

    cmd(1, 'h70, 'h12, 0, 0, 1, 'h70);
    look(32'h0007_0000, 0, 32'h0, "R9 invalidate wins");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule